// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable serial EEPROM that answers on a two-wire bus. The storage is a byte array split into 32-byte pages. It runs on a fast system clock. It synchronizes the bus clock and data lines and finds their edges by oversampling. It never drives the data line high: it only asserts a pull-low enable, which the pad turns into an open-drain output. So any number of other open-drain devices can share the line.

A controller selects the block with a select byte. The select byte carries a fixed family prefix, three strap address bits and a direction bit. A write frame carries a two-byte word address and then zero or more data bytes. The data bytes are gathered in a page buffer and written into the array once the STOP arrives. Reads stream bytes from an internal address counter for as long as the controller acknowledges. A random read is a write frame that carries only the address, followed by a repeated START. A protect input shields the top quarter of the array from writes.

The default configuration is an 11-bit array (2 KB) so that elaboration stays small. Setting `ADDR_W` to 13 gives the 8 KB, 256-page organization. At the pad, the strap and protect inputs are expected to carry pull-downs, so an unconnected pin reads as 0.

Top module: `twi_eeprom_target`

## Requirements
- R1: The block samples SDA on rising SCL edges. It changes its own pull-low output only while SCL is low, after a falling edge. The level it drives stays constant throughout each SCL high phase.
- R2: After reset, and after every STOP condition, `sda_pull_o` is 0 (line released).
- R3: The select byte is sent MSB first. It is `1010`, then `strap_i[2]`, `strap_i[1]`, `strap_i[0]`, then R/W, where 0 means write. On a match, the block holds `sda_pull_o` at 1 through the ninth clock. On a mismatch, it acknowledges nothing, including later bytes, until the next START.
- R4: A write frame sends the high address byte first, then the low address byte. The word address is the low `ADDR_W` bits of that 16-bit value, so the excess high bits are ignored. Both address bytes are acknowledged.
- R5: Every data byte in a write frame is acknowledged. The first byte goes to the received address. For each later byte, only the low 5 address bits advance, wrapping within the same 32-byte page. The bytes reach the array only after STOP.
- R6: A START inside a frame abandons the frame and discards any data bytes not yet committed. Select decoding then restarts, so a repeated START after the address bytes forms a random read.
- R7: While `wp_i` is 1, data bytes whose address has its two top bits equal to `11` are acknowledged but not stored. Addresses below that quarter are stored. While `wp_i` is 0, every address is stored.
- R8: A read returns the byte at the address counter and then advances the counter by 1 across the whole array, wrapping from the top address to 0. A controller ACK (SDA low in the ninth clock) requests the next byte. A NACK ends the transfer.
- R9: A read frame with no address phase starts from the counter value left by the previous frame. After a write, that is the wrapped in-page address following the last data byte. After a read, it is the address following the last byte returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device address straps, bit 2 sent first |
| wp_i | input | 1 | 1 blocks writes to the top quarter of the array |

## Verification
The line synchronizer adds about three system clocks between a pin change and the block reacting to it. The bench holds each SCL phase for 10 to 20 system clocks, so every result has settled long before it is sampled. Acknowledge and read data bits are sampled in the middle of the SCL high phase. Read bits are sampled twice in that phase to confirm they do not move. After each STOP, the bench waits 60 clocks before sampling the released line or starting another frame: the page buffer needs 32 clocks to drain into the array, plus the synchronizer delay. A reference byte array in the bench predicts every read, including page wrap and protected bytes. Read bytes go to a scoreboard that compares them in order.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DEV,
    PH_DEV_ACK,
    PH_AHI,
    PH_AHI_ACK,
    PH_ALO,
    PH_ALO_ACK,
    PH_WDAT,
    PH_WDAT_ACK,
    PH_RDAT,
    PH_RACK,
    PH_WAIT
  } phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear,
  input  logic              commit,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_slot,
  output logic [DATA_W-1:0] mem_data,
  output logic              busy
);

  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  mask_q, mask_n;
  logic [PAGE_W-1:0] idx_q, idx_n;
  logic              busy_q, busy_n;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_slot] <= wr_data;
  end

  always_comb begin
    mask_n = mask_q;
    idx_n  = idx_q;
    busy_n = busy_q;
    if (busy_q) begin
      idx_n = idx_q + 1'b1;
      if (idx_q == PAGE_W'(DEPTH - 1)) begin
        busy_n = 1'b0;
        mask_n = '0;
      end
    end else if (clear) begin
      mask_n = '0;
    end else begin
      if (wr_en) mask_n[wr_slot] = 1'b1;
      if (commit && (|mask_q)) begin
        busy_n = 1'b1;
        idx_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      mask_q <= mask_n;
      idx_q  <= idx_n;
      busy_q <= busy_n;
    end
  end

  assign mem_we   = busy_q & mask_q[idx_q];
  assign mem_slot = idx_q;
  assign mem_data = slot_q[idx_q];
  assign busy     = busy_q;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
    rdata <= cell_q[raddr];
  end

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam int PAGE_NUM_W = ADDR_W - PAGE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  phase_e                phase_q, phase_n;
  logic [3:0]            bitcnt_q, bitcnt_n;
  logic [7:0]            shreg_q, shreg_n;
  logic [7:0]            txsr_q, txsr_n;
  logic                  oe_q, oe_n;
  logic                  mack_q, mack_n;
  logic                  rnw_q, rnw_n;
  logic [7:0]            ahi_q, ahi_n;
  logic [ADDR_W-1:0]     addr_q, addr_n;
  logic [PAGE_NUM_W-1:0] page_q, page_n;

  logic                  pb_wr, pb_clear, pb_commit, pb_busy;
  logic                  arr_we;
  logic [PAGE_W-1:0]     pb_slot;
  logic [7:0]            pb_data;
  logic [ADDR_W-1:0]     arr_waddr;
  logic [7:0]            rd_data;
  logic                  load_tx;
  logic                  dev_match;
  logic                  protect;
  logic [15:0]           full_addr;
  logic                  in_idle, in_wait;

  assign dev_match = (shreg_q[7:4] == DEV_PREFIX) && (shreg_q[3:1] == strap_i);
  assign protect   = wp_i && (addr_q[ADDR_W-1 -: 2] == 2'b11);
  assign full_addr = {ahi_q, shreg_q};
  assign arr_waddr = {page_q, pb_slot};
  assign in_idle   = (phase_q == PH_IDLE);
  assign in_wait   = (phase_q == PH_WAIT);

  twi_page_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) u_page (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (pb_wr),
    .wr_slot  (addr_q[PAGE_W-1:0]),
    .wr_data  (shreg_q),
    .clear    (pb_clear),
    .commit   (pb_commit),
    .mem_we   (arr_we),
    .mem_slot (pb_slot),
    .mem_data (pb_data),
    .busy     (pb_busy)
  );

  twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (pb_data),
    .raddr (addr_q),
    .rdata (rd_data)
  );

  always_comb begin
    phase_n   = phase_q;
    bitcnt_n  = bitcnt_q;
    shreg_n   = shreg_q;
    txsr_n    = txsr_q;
    oe_n      = oe_q;
    mack_n    = mack_q;
    rnw_n     = rnw_q;
    ahi_n     = ahi_q;
    addr_n    = addr_q;
    page_n    = page_q;
    pb_wr     = 1'b0;
    pb_clear  = 1'b0;
    pb_commit = 1'b0;
    load_tx   = 1'b0;

    if (start_det) begin
      phase_n  = PH_DEV;
      bitcnt_n = '0;
      oe_n     = 1'b0;
      pb_clear = 1'b1;
    end else if (stop_det) begin
      phase_n   = PH_IDLE;
      bitcnt_n  = '0;
      oe_n      = 1'b0;
      pb_commit = 1'b1;
    end else begin
      unique case (phase_q)
        PH_DEV, PH_AHI, PH_ALO, PH_WDAT: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_n  = {shreg_q[6:0], sda_s};
            bitcnt_n = bitcnt_q + 4'd1;
          end
          if (scl_fall && bitcnt_q == 4'd8) begin
            bitcnt_n = '0;
            oe_n     = 1'b1;
            unique case (phase_q)
              PH_DEV: begin
                if (dev_match) begin
                  rnw_n   = shreg_q[0];
                  phase_n = PH_DEV_ACK;
                end else begin
                  oe_n    = 1'b0;
                  phase_n = PH_WAIT;
                end
              end
              PH_AHI: begin
                ahi_n   = shreg_q;
                phase_n = PH_AHI_ACK;
              end
              PH_ALO: begin
                addr_n  = full_addr[ADDR_W-1:0];
                phase_n = PH_ALO_ACK;
              end
              default: begin
                pb_wr   = ~protect;
                page_n  = addr_q[ADDR_W-1:PAGE_W];
                addr_n  = {addr_q[ADDR_W-1:PAGE_W], PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1)};
                phase_n = PH_WDAT_ACK;
              end
            endcase
          end
        end
        PH_DEV_ACK, PH_AHI_ACK, PH_ALO_ACK, PH_WDAT_ACK: begin
          if (scl_fall) begin
            oe_n     = 1'b0;
            bitcnt_n = '0;
            unique case (phase_q)
              PH_DEV_ACK: begin
                if (rnw_q) load_tx = 1'b1;
                else       phase_n = PH_AHI;
              end
              PH_AHI_ACK: phase_n = PH_ALO;
              default:    phase_n = PH_WDAT;
            endcase
          end
        end
        PH_RDAT: begin
          if (scl_rise) bitcnt_n = bitcnt_q + 4'd1;
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              oe_n     = 1'b0;
              bitcnt_n = '0;
              phase_n  = PH_RACK;
            end else begin
              txsr_n = {txsr_q[6:0], 1'b0};
              oe_n   = ~txsr_q[6];
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack_q) load_tx = 1'b1;
            else        phase_n = PH_WAIT;
          end
        end
        default: ;
      endcase

      if (load_tx) begin
        txsr_n   = rd_data;
        oe_n     = ~rd_data[7];
        addr_n   = addr_q + 1'b1;
        bitcnt_n = '0;
        phase_n  = PH_RDAT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txsr_q   <= '0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b0;
      rnw_q    <= 1'b0;
      ahi_q    <= '0;
      addr_q   <= '0;
      page_q   <= '0;
    end else begin
      phase_q  <= phase_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      txsr_q   <= txsr_n;
      oe_q     <= oe_n;
      mack_q   <= mack_n;
      rnw_q    <= rnw_n;
      ahi_q    <= ahi_n;
      addr_q   <= addr_n;
      page_q   <= page_n;
    end
  end

  assign sda_pull_o = oe_q;

endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              sda_pull_o,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_waddr,
  input logic              wp_i,
  input logic              in_idle,
  input logic              in_wait
);

  assert_pull_moves_low_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  assert_release_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    stop_det |=> !sda_pull_o);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_idle |-> !sda_pull_o);

  assert_mismatch_silent_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_wait |-> !sda_pull_o);

  assert_commit_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    arr_we |-> in_idle);

  assert_protect_guard_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (arr_we && wp_i) |-> (arr_waddr[ADDR_W-1 -: 2] != 2'b11));

endmodule

bind twi_eeprom_target twi_eeprom_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .sda_pull_o (sda_pull_o),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .arr_we     (arr_we),
  .arr_waddr  (arr_waddr),
  .wp_i       (wp_i),
  .in_idle    (in_idle),
  .in_wait    (in_wait)
);

// File: tb/twi_eeprom_target_test.sv
module twi_eeprom_target_test;

  localparam int AW    = 11;
  localparam int PW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 10;
  localparam int H     = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic       sda_m;
  logic       sda_pull;
  logic       sda_bus;
  logic [2:0] strap;
  logic       wp;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  twi_eeprom_target uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .strap_i    (strap),
    .wp_i       (wp)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]    model [DEPTH];
  logic [AW-1:0] mptr;
  logic [7:0]    exp_q [$];
  logic [7:0]    got_q [$];
  string         tag_q [$];
  string         cur_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl   = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl   = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl   = 1'b1; hold(Q);
    sda_m = 1'b1; hold(60);
    check(sda_pull == 1'b0, "R2", "line released after STOP", int'(sda_pull), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl = 1'b1;   hold(H);
      scl = 1'b0;   hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl = 1'b1;   hold(Q);
    ack = ~sda_bus;
    hold(Q);
    scl = 1'b0;   hold(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic unst;
    logic v1;
    unst  = 1'b0;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl = 1'b1; hold(Q);
      v1 = sda_bus; hold(Q);
      if (sda_bus !== v1) unst = 1'b1;
      b[i] = v1;
      scl = 1'b0;
    end
    hold(Q);
    sda_m = mack ? 1'b0 : 1'b1; hold(Q);
    scl = 1'b1; hold(H);
    scl = 1'b0; hold(Q);
    sda_m = 1'b1;
    check(!unst, "R1", "read bits stable while SCL high", int'(unst), 0);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] seed,
                          input string req);
    logic          ack;
    logic [AW-1:0] base;
    logic [AW-1:0] wa;
    logic [7:0]    d;
    base = a[AW-1:0];
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    check(ack, "R3", "select ack (write)", int'(ack), 1);
    send_byte(a[15:8], ack);
    check(ack, "R4", "high address ack", int'(ack), 1);
    send_byte(a[7:0], ack);
    check(ack, "R4", "low address ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 7);
      send_byte(d, ack);
      check(ack, req, "data byte ack", int'(ack), 1);
      wa = {base[AW-1:PW], PW'(base[PW-1:0] + k)};
      if (!(wp && wa[AW-1 -: 2] == 2'b11)) model[wa] = d;
    end
    bus_stop();
    mptr = {base[AW-1:PW], PW'(base[PW-1:0] + n)};
  endtask

  task automatic read_body(input int n);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[mptr]);
      tag_q.push_back(cur_tag);
      mptr = mptr + 1'b1;
      recv_byte(k < n - 1, b);
      got_q.push_back(b);
    end
    bus_stop();
  endtask

  task automatic random_read(input logic [15:0] a, input int n, input string req);
    logic ack;
    cur_tag = req;
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    check(ack, "R3", "select ack (dummy write)", int'(ack), 1);
    send_byte(a[15:8], ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, ack);
    check(ack, "R6", "select ack after repeated START", int'(ack), 1);
    mptr = a[AW-1:0];
    read_body(n);
  endtask

  task automatic current_read(input int n, input string req);
    logic ack;
    cur_tag = req;
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, ack);
    check(ack, "R3", "select ack (read)", int'(ack), 1);
    read_body(n);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (got_q.size() != 0 && exp_q.size() != 0) begin
        logic [7:0] g;
        logic [7:0] e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g === e, t, "read data", int'(g), int'(e));
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    rst_n = 1'b0;
    scl   = 1'b1;
    sda_m = 1'b1;
    strap = 3'b000;
    wp    = 1'b0;
    hold(5);
    rst_n = 1'b1;
    hold(10);
    check(sda_pull == 1'b0, "R2", "released after reset", int'(sda_pull), 0);

    // page write, sequential read across top of array
    do_write(16'h0000, 2, 8'h11, "R5");
    do_write(16'h07FE, 2, 8'h21, "R5");
    random_read(16'h07FE, 4, "R8");

    // current-address reads after read and after write
    do_write(16'h0040, 3, 8'h31, "R5");
    random_read(16'h0040, 2, "R8");
    current_read(1, "R9");
    do_write(16'h005E, 4, 8'h71, "R5");
    current_read(1, "R9");
    random_read(16'h005E, 2, "R5");
    random_read(16'h0040, 2, "R5");

    // ignored high address bits
    do_write(16'hF923, 1, 8'h81, "R4");
    random_read(16'h0123, 1, "R4");

    // write protect of top quarter
    do_write(16'h0700, 2, 8'h41, "R7");
    do_write(16'h0600, 1, 8'h45, "R7");
    wp = 1'b1;
    hold(5);
    do_write(16'h0700, 2, 8'h51, "R7");
    do_write(16'h05FF, 1, 8'h55, "R7");
    do_write(16'h0600, 1, 8'h59, "R7");
    random_read(16'h0700, 2, "R7");
    random_read(16'h05FF, 2, "R7");
    wp = 1'b0;
    hold(5);

    // aborted write frame
    do_write(16'h0200, 1, 8'h61, "R5");
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, ack);
    send_byte(8'h02, ack);
    send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    check(ack, "R6", "data ack before abort", int'(ack), 1);
    bus_start();
    bus_stop();
    random_read(16'h0200, 1, "R6");

    // select mismatches
    bus_start();
    send_byte(8'hA2, ack);
    check(!ack, "R3", "wrong strap not acked", int'(ack), 0);
    send_byte(8'h00, ack);
    check(!ack, "R3", "byte after mismatch ignored", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'hB0, ack);
    check(!ack, "R3", "wrong prefix not acked", int'(ack), 0);
    bus_stop();

    // non-zero strap
    strap = 3'b101;
    hold(5);
    do_write(16'h0300, 1, 8'h91, "R3");
    random_read(16'h0300, 1, "R3");
    strap = 3'b000;

    hold(20);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule